// File: doc/BRIEF.md
# General-Purpose Capture/Compare Timer

This block is a 32-bit up-counting timer with a register slave port. Software starts and stops the counter with a control bit. The counting rate can be slowed by a power-of-two prescaler. At the top of its range the counter either returns to zero or, in auto-reload mode, restarts from a load register. A match register is compared with each new count. A synchronized capture pin stores the running count on a chosen edge. Overflow, match and capture each set a sticky status bit. Each status bit has its own enable bit, and the enabled bits together drive one interrupt line. The timer pin either toggles or gives a one-cycle pulse on overflow and match events, and a polarity bit can invert it. A separate general-purpose output follows a bit in the control register.

The port uses the functional clock as its bus clock. Reads are combinational from the word address. A write completes at the clock edge on which select and write are both high, and a write may be a full word or a halfword. All registers stay accessible while the counter runs. Byte offsets are: control 0x00, count 0x04, load 0x08, match 0x0C, capture 0x10 (read only), status 0x14, enable 0x18. Unmapped offsets read as zero and ignore writes.

Two small state machines set the behaviour. The counter machine has the states CNT_IDLE and CNT_RUN. It takes transition *start* (CNT_IDLE to CNT_RUN) when the run bit is 1 and transition *stop* (CNT_RUN to CNT_IDLE) when the run bit is 0. The pin machine has the states OUT_LO and OUT_HI. In toggle mode, *flip* moves between them on any event. In pulse mode, *fire* moves to OUT_HI on an event, *hold* stays in OUT_HI on a further event, and *drop* returns to OUT_LO in a cycle with no event.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads 0, and `irq`, `pwm_out` and `gpo_out` are 0.
- R2: The count advances only in CNT_RUN. When the run bit (control bit 0) is cleared, the count stops changing within two cycles.
- R3: Each count step takes 2^n clock cycles when prescaler-enable (bit 2) is 1, where n is control bits 6:3. Values of n above 8 act as 8. When bit 2 is 0 the count advances every cycle.
- R4: A step from 0xFFFFFFFF sets status bit 0. The count then goes to 0, or to the load value if auto-reload (bit 1) is 1.
- R5: When match-enable (bit 7) is 1, a step onto the match value sets status bit 1. When bit 7 is 0, no match event occurs.
- R6: With capture-enable (bit 8) set, an edge on `cap_in` selected by bits 10:9 stores the count into the capture register and sets status bit 2. The edge codes are 01 rising, 10 falling and 11 both. The pin passes through a two-flop synchronizer first. Writes to the capture register are ignored.
- R7: `irq` is the OR of status AND enable (bits 2:0). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: With bit 11 at 0 the pin machine toggles on any overflow or match event. With bit 11 at 1 it is high for one cycle per event run. `pwm_out` is the state XOR the polarity bit 12.
- R9: `gpo_out` equals control bit 13.
- R10: When `bus_half` is 1, a write changes only the halfword chosen by address bit 1. That halfword takes its data from the matching lane of `bus_wdata`, with bits 31:16 for address bit 1 = 1. When `bus_half` is 0, a write changes the whole word.
- R11: A software write to the count takes priority over a step in the same cycle, and it takes effect while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_half | input | 1 | 1 = halfword write, 0 = word write |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cap_in | input | 1 | Asynchronous capture trigger |
| pwm_out | output | 1 | Trigger/PWM pin |
| gpo_out | output | 1 | General-purpose output |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions are checked on every cycle. They cover the counter holding still outside CNT_RUN, the next value after a step from the top of the range in both wrap modes, a step in every running cycle when the prescaler is off, the interrupt line being high only when some enabled status bit is set, and a pulse-mode pin dropping after a cycle with no event. Only the bench scenarios can show the other behaviours. These are the actual step rate for different prescaler settings and the clamp above eight, the capture value and its edge selection through the synchronizer, clearing of one status bit without the others, the number of pin transitions and high cycles around a match, and halfword lane merging.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef struct packed {
        logic       gpo;
        logic       out_pol;
        logic       out_pulse;
        logic [1:0] cap_edge;
        logic       cap_en;
        logic       cmp_en;
        logic [3:0] pre_n;
        logic       pre_en;
        logic       reload;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // word indices of the register map
    localparam int A_CTRL  = 0;
    localparam int A_COUNT = 1;
    localparam int A_LOAD  = 2;
    localparam int A_MATCH = 3;
    localparam int A_CAPT  = 4;
    localparam int A_STAT  = 5;
    localparam int A_IEN   = 6;

    localparam int N_IRQ = 3;

    typedef enum logic {CNT_IDLE, CNT_RUN} cnt_state_e;
    typedef enum logic {OUT_LO, OUT_HI}    out_state_e;

endpackage

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int W       = 32,
    parameter int PRE_MAX = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_req,
    input  logic         reload_en,
    input  logic         pre_en,
    input  logic [3:0]   pre_n,
    input  logic         cmp_en,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wval,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] count,
    output logic         tick,
    output logic         ovf_ev,
    output logic         cmp_ev,
    output logic         is_run
);
    localparam int PW = PRE_MAX + 1;

    cnt_state_e st_q, st_d;
    logic [3:0]    n_eff;
    logic [PW-1:0] pre_q, pre_lim;
    logic          wrap;
    logic [W-1:0]  cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_IDLE: if (run_req)  st_d = CNT_RUN;   // start
            CNT_RUN:  if (!run_req) st_d = CNT_IDLE;  // stop
        endcase
    end

    assign is_run  = (st_q == CNT_RUN);
    assign n_eff   = (pre_n > 4'(PRE_MAX)) ? 4'(PRE_MAX) : pre_n;
    assign pre_lim = pre_en ? ((PW'(1) << n_eff) - PW'(1)) : '0;
    assign tick    = is_run && (pre_q >= pre_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (!is_run) pre_q <= '0;
        else if (tick)    pre_q <= '0;
        else              pre_q <= pre_q + PW'(1);
    end

    assign wrap   = (count == '1);
    assign cnt_nx = wrap ? (reload_en ? load_val : '0) : count + W'(1);
    assign ovf_ev = tick && !cnt_wr && wrap;
    assign cmp_ev = tick && !cnt_wr && cmp_en && (cnt_nx == match_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= cnt_wval;
        else if (tick)   count <= cnt_nx;
    end
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       en,
    input  logic [1:0] edge_sel,
    output logic       cap_ev
);
    logic [SYNC:0] sh_q;
    logic          rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC-1:0], pin};
    end

    assign rise   =  sh_q[SYNC-1] & ~sh_q[SYNC];
    assign fall   = ~sh_q[SYNC-1] &  sh_q[SYNC];
    assign cap_ev = en && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
endmodule

// File: rtl/gpt_pwm.sv
module gpt_pwm
    import gpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_ovf,
    input  logic ev_cmp,
    input  logic pulse_mode,
    input  logic polarity,
    output logic pin,
    output logic out_hi
);
    out_state_e st_q, st_d;
    logic ev_any;

    assign ev_any = ev_ovf | ev_cmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OUT_LO;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_LO: if (ev_any) st_d = OUT_HI;                 // flip / fire
            OUT_HI: begin
                if (pulse_mode) st_d = ev_any ? OUT_HI : OUT_LO; // hold / drop
                else if (ev_any) st_d = OUT_LO;                  // flip
            end
        endcase
    end

    always_comb begin
        out_hi = (st_q == OUT_HI);
        pin    = out_hi ^ polarity;
    end
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_half,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] count,
    input  logic          ovf_ev,
    input  logic          cmp_ev,
    input  logic          cap_ev,
    output ctrl_t         ctrl,
    output logic [DW-1:0] load_val,
    output logic [DW-1:0] match_val,
    output logic          cnt_wr,
    output logic [DW-1:0] cnt_wval,
    output logic          irq
);
    localparam int IW = AW - 2;
    localparam int HW = DW / 2;

    logic [IW-1:0]    widx;
    logic             wen;
    logic [DW-1:0]    lane_m, w_eff, ctrl_wr, load_wr, match_wr;
    logic [DW-1:0]    cap_q;
    logic [N_IRQ-1:0] stat_q, ien_q, stat_set, stat_clr;
    logic             unused_bits;

    assign widx        = bus_addr[AW-1:2];
    assign wen         = bus_sel & bus_wr;
    assign unused_bits = &{1'b0, bus_addr[0], w_eff[DW-1:N_IRQ]};
    assign lane_m      = !bus_half ? '1 :
                         (bus_addr[1] ? {{HW{1'b1}}, {HW{1'b0}}} : {{HW{1'b0}}, {HW{1'b1}}});
    assign w_eff       = bus_wdata & lane_m;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] msk,
                                            input logic [DW-1:0] nw);
        return (old & ~msk) | (nw & msk);
    endfunction

    assign ctrl_wr  = merge({{(DW-CTRL_W){1'b0}}, ctrl}, lane_m, bus_wdata);
    assign load_wr  = merge(load_val, lane_m, bus_wdata);
    assign match_wr = merge(match_val, lane_m, bus_wdata);
    assign cnt_wval = merge(count, lane_m, bus_wdata);
    assign cnt_wr   = wen && (widx == IW'(A_COUNT));

    assign stat_set = {cap_ev, cmp_ev, ovf_ev};
    assign stat_clr = (wen && widx == IW'(A_STAT)) ? w_eff[N_IRQ-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            load_val  <= '0;
            match_val <= '0;
            ien_q     <= '0;
        end else if (wen) begin
            if (widx == IW'(A_CTRL))  ctrl      <= ctrl_t'(ctrl_wr[CTRL_W-1:0]);
            if (widx == IW'(A_LOAD))  load_val  <= load_wr;
            if (widx == IW'(A_MATCH)) match_val <= match_wr;
            if (widx == IW'(A_IEN))   ien_q     <= ien_q & ~lane_m[N_IRQ-1:0] | w_eff[N_IRQ-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            cap_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (cap_ev) cap_q <= count;
        end
    end

    assign irq = |(stat_q & ien_q);

    always_comb begin
        case (widx)
            IW'(A_CTRL):  bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
            IW'(A_COUNT): bus_rdata = count;
            IW'(A_LOAD):  bus_rdata = load_val;
            IW'(A_MATCH): bus_rdata = match_val;
            IW'(A_CAPT):  bus_rdata = cap_q;
            IW'(A_STAT):  bus_rdata = {{(DW-N_IRQ){1'b0}}, stat_q};
            IW'(A_IEN):   bus_rdata = {{(DW-N_IRQ){1'b0}}, ien_q};
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 10,
    parameter int PRE_MAX = 8,
    parameter int SYNC    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_half,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          cap_in,
    output logic          pwm_out,
    output logic          gpo_out,
    output logic          irq
);
    ctrl_t         ctrl;
    logic [DW-1:0] count, load_val, match_val, cnt_wval;
    logic          cnt_wr, tick, is_run, ovf_ev, cmp_ev, cap_ev, out_hi;

    gpt_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_half(bus_half),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev), .cap_ev(cap_ev),
        .ctrl(ctrl), .load_val(load_val), .match_val(match_val),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .irq(irq)
    );

    gpt_core #(.W(DW), .PRE_MAX(PRE_MAX)) u_core (
        .clk(clk), .rst_n(rst_n), .run_req(ctrl.run), .reload_en(ctrl.reload),
        .pre_en(ctrl.pre_en), .pre_n(ctrl.pre_n), .cmp_en(ctrl.cmp_en),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .load_val(load_val), .match_val(match_val),
        .count(count), .tick(tick), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev), .is_run(is_run)
    );

    gpt_capture #(.SYNC(SYNC)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_in), .en(ctrl.cap_en),
        .edge_sel(ctrl.cap_edge), .cap_ev(cap_ev)
    );

    gpt_pwm u_pwm (
        .clk(clk), .rst_n(rst_n), .ev_ovf(ovf_ev), .ev_cmp(cmp_ev),
        .pulse_mode(ctrl.out_pulse), .polarity(ctrl.out_pol), .pin(pwm_out), .out_hi(out_hi)
    );

    assign gpo_out = ctrl.gpo;
endmodule

// File: rtl/gpt_chk.sv
module gpt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] count,
    input logic [31:0] load_val,
    input logic        tick,
    input logic        is_run,
    input logic        cnt_wr,
    input logic        reload,
    input logic        pre_en,
    input logic [2:0]  stat,
    input logic [2:0]  ien,
    input logic        irq,
    input logic        pulse,
    input logic        out_hi,
    input logic        ev_any
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_run && !cnt_wr) |=> $stable(count));

    // R3
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_run && !pre_en) |-> tick);

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !reload && count == 32'hFFFF_FFFF) |=> (count == 32'h0));

    // R4
    wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && reload && count == 32'hFFFF_FFFF) |=> (count == $past(load_val)));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat & ien) != 3'b000));

    // R8
    pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && out_hi && !ev_any) |=> !out_hi);
endmodule

bind gp_timer gpt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .count(count), .load_val(load_val), .tick(tick),
    .is_run(is_run), .cnt_wr(cnt_wr), .reload(ctrl.reload), .pre_en(ctrl.pre_en),
    .stat(u_regs.stat_q), .ien(u_regs.ien_q), .irq(irq), .pulse(ctrl.out_pulse),
    .out_hi(out_hi), .ev_any(ovf_ev | cmp_ev)
);

// File: tb/sim_gp_timer.sv
module sim_gp_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] O_CTRL = 10'h00, O_CNT = 10'h04, O_LOAD = 10'h08,
                           O_MATCH = 10'h0C, O_CAPT = 10'h10, O_STAT = 10'h14, O_IEN = 10'h18;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0, cap_in = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        pwm_out, gpo_out, irq;
    int checks = 0, errors = 0;
    int n_tog = 0, n_hi = 0;
    logic prev_pwm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gp_timer u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_in(cap_in), .pwm_out(pwm_out),
        .gpo_out(gpo_out), .irq(irq));

    always @(negedge clk) begin
        if (pwm_out !== prev_pwm) n_tog = n_tog + 1;
        if (pwm_out) n_hi = n_hi + 1;
        prev_pwm = pwm_out;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input bit half = 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_half = half;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_half = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 7; i++) begin
            rd(10'(i * 4), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk(!irq && !pwm_out && !gpo_out, "R1 outputs reset", {irq, pwm_out, gpo_out}, 0);
    endtask

    task automatic t_runstop();
        logic [31:0] a, b;
        wr(O_CNT, 0);
        wr(O_CTRL, 32'h1);
        rd(O_CNT, a);
        repeat (40) @(posedge clk);
        rd(O_CNT, b);
        chk(b - a == 40, "R2 counts while running", b - a, 40);
        wr(O_CTRL, 32'h0);
        repeat (3) @(posedge clk);
        rd(O_CNT, a);
        repeat (20) @(posedge clk);
        rd(O_CNT, b);
        chk(a == b, "R2 holds when stopped", b, a);
    endtask

    task automatic rate(input logic [31:0] ctl, input int cyc, input int exp, input string req);
        logic [31:0] a, b;
        wr(O_CTRL, ctl);
        repeat (300) @(posedge clk);
        rd(O_CNT, a);
        repeat (cyc) @(posedge clk);
        rd(O_CNT, b);
        chk(b - a == 32'(exp), req, b - a, 32'(exp));
    endtask

    task automatic t_presc();
        rate(32'h15, 40, 10, "R3 divide by 4");
        rate(32'h11, 40, 40, "R3 prescaler off ignores n");
        rate(32'h65, 512, 2, "R3 n above 8 clamps to 256");
        wr(O_CTRL, 0);
    endtask

    task automatic t_ovf();
        logic [31:0] v;
        wr(O_STAT, 7);
        wr(O_CNT, 32'hFFFF_FFFD);
        wr(O_LOAD, 32'h100);
        wr(O_CTRL, 32'h3);
        repeat (10) @(posedge clk);
        wr(O_CTRL, 0);
        rd(O_CNT, v);
        chk(v >= 32'h100 && v < 32'h110, "R4 reload from load value", v, 32'h100);
        rd(O_STAT, v);
        chk(v == 1, "R4 overflow flag", v, 1);
        wr(O_STAT, 7);
        wr(O_CNT, 32'hFFFF_FFFD);
        wr(O_CTRL, 32'h1);
        repeat (10) @(posedge clk);
        wr(O_CTRL, 0);
        rd(O_CNT, v);
        chk(v < 32'h10, "R4 wrap to zero", v, 0);
        rd(O_STAT, v);
        chk(v == 1, "R4 overflow flag free run", v, 1);
        wr(O_STAT, 7);
    endtask

    task automatic t_cmp();
        logic [31:0] v;
        wr(O_IEN, 0);
        wr(O_MATCH, 32'h50);
        wr(O_CNT, 32'h40);
        wr(O_CTRL, 32'h1);
        repeat (30) @(posedge clk);
        wr(O_CTRL, 0);
        rd(O_STAT, v);
        chk(v == 0, "R5 no match when disabled", v, 0);
        wr(O_CNT, 32'h40);
        wr(O_CTRL, 32'h81);
        repeat (30) @(posedge clk);
        wr(O_CTRL, 0);
        rd(O_STAT, v);
        chk(v == 2, "R5 match flag", v, 2);
        chk(irq == 0, "R7 masked irq low", irq, 0);
        wr(O_IEN, 2);
        @(negedge clk);
        chk(irq == 1, "R7 enabled irq high", irq, 1);
        wr(O_STAT, 1);
        rd(O_STAT, v);
        chk(v == 2 && irq, "R7 clearing other bit keeps match", v, 2);
        wr(O_STAT, 2);
        rd(O_STAT, v);
        chk(v == 0 && !irq, "R7 write one clears", v, 0);
        wr(O_IEN, 0);
    endtask

    task automatic t_cap();
        logic [31:0] v;
        wr(O_CTRL, 32'h300);
        wr(O_CNT, 32'h1234);
        @(negedge clk) cap_in = 1'b1;
        repeat (5) @(posedge clk);
        rd(O_CAPT, v);
        chk(v == 32'h1234, "R6 rising capture", v, 32'h1234);
        rd(O_STAT, v);
        chk(v == 4, "R6 capture flag", v, 4);
        wr(O_STAT, 4);
        wr(O_CNT, 32'h5555);
        @(negedge clk) cap_in = 1'b0;
        repeat (5) @(posedge clk);
        rd(O_CAPT, v);
        chk(v == 32'h1234, "R6 falling edge ignored", v, 32'h1234);
        rd(O_STAT, v);
        chk(v == 0, "R6 no flag on ignored edge", v, 0);
        wr(O_CTRL, 32'h700);
        wr(O_CNT, 32'h7777);
        @(negedge clk) cap_in = 1'b1;
        repeat (5) @(posedge clk);
        wr(O_CNT, 32'h8888);
        @(negedge clk) cap_in = 1'b0;
        repeat (5) @(posedge clk);
        rd(O_CAPT, v);
        chk(v == 32'h8888, "R6 both edges", v, 32'h8888);
        wr(O_CAPT, 32'hFFFF);
        rd(O_CAPT, v);
        chk(v == 32'h8888, "R6 capture write ignored", v, 32'h8888);
        wr(O_STAT, 7);
        wr(O_CTRL, 0);
    endtask

    task automatic t_pwm();
        int t0, h0;
        wr(O_MATCH, 32'h50);
        wr(O_CNT, 32'h4D);
        t0 = n_tog;
        wr(O_CTRL, 32'h81);
        repeat (20) @(posedge clk);
        wr(O_CTRL, 0);
        @(negedge clk);
        chk(n_tog - t0 == 1, "R8 toggle once per match", 32'(n_tog - t0), 1);
        wr(O_CTRL, 32'h800);
        repeat (2) @(posedge clk);
        wr(O_CNT, 32'h4D);
        h0 = n_hi;
        wr(O_CTRL, 32'h881);
        repeat (20) @(posedge clk);
        wr(O_CTRL, 32'h800);
        @(negedge clk);
        chk(n_hi - h0 == 1, "R8 one-cycle pulse", 32'(n_hi - h0), 1);
        wr(O_CTRL, 32'h1800);
        @(negedge clk);
        chk(pwm_out == 1, "R8 polarity inverts idle", pwm_out, 1);
        wr(O_STAT, 7);
        wr(O_CTRL, 0);
    endtask

    task automatic t_gpo();
        wr(O_CTRL, 32'h2000);
        @(negedge clk);
        chk(gpo_out == 1, "R9 gpo set", gpo_out, 1);
        wr(O_CTRL, 0);
        @(negedge clk);
        chk(gpo_out == 0, "R9 gpo clear", gpo_out, 0);
    endtask

    task automatic t_half();
        logic [31:0] v;
        wr(O_MATCH, 32'h1111_2222);
        wr(10'h0E, 32'hABCD_0000, 1'b1);
        rd(O_MATCH, v);
        chk(v == 32'hABCD_2222, "R10 upper halfword", v, 32'hABCD_2222);
        wr(10'h0C, 32'h9999_5678, 1'b1);
        rd(O_MATCH, v);
        chk(v == 32'hABCD_5678, "R10 lower halfword", v, 32'hABCD_5678);
    endtask

    task automatic t_live();
        logic [31:0] v;
        wr(O_CTRL, 32'h1);
        repeat (5) @(posedge clk);
        wr(O_CNT, 32'h1000);
        rd(O_CNT, v);
        chk(v >= 32'h1000 && v <= 32'h1002, "R11 write while running", v, 32'h1001);
        wr(O_CTRL, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_runstop();
        t_presc();
        t_ovf();
        t_cmp();
        t_cap();
        t_pwm();
        t_gpo();
        t_half();
        t_live();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule